// File: doc/BRIEF.md
# SDRAM Write-Burst Truncation Sequencer

This block is the write-side command sequencer of a single-data-rate SDRAM controller. It takes one write request at a time. Each request names a bank, a start column, a burst length, how many leading beats are really wanted, a truncation choice and an auto-precharge flag. The block issues the WRITE command and streams the beats onto the data pins. Data comes from an input stream that the block pulls one word per beat.

A burst can end in three ways. It can run to its full length. It can be cut short by a READ to the same bank. It can be cut short by a single-bank PRECHARGE placed the write-recovery time after the last wanted beat. While it waits for that PRECHARGE, the data mask stays high, so unwanted beats are never written. A per-bank timer keeps the next WRITE to a bank away until the row-precharge time has passed. That precharge can be explicit, or implied by auto precharge. The pins are modelled at cycle level: the four command strobes form one bus, and the data bus is split into an output value and an output enable.

Both timing parameters are whole clock cycles, rounded up from the required times at the clock in use. The write-recovery parameter must be at least 2, because the required time is one full clock plus a margin. The row-precharge parameter must be at least 1. The address bus is wider than 10 bits, and bit 10 carries the auto-precharge flag.

Top module: `sdram_wtrunc_seq`

## Requirements
- R1: After reset the command bus shows NOP (`sd_cmd` = {cs_n,ras_n,cas_n,we_n} = 4'b0111), `sd_dqm` is 1, `sd_dq_oe` is 0 and `req_ready` is 1.
- R2: A request accepted on a clock edge (`req_valid` and `req_ready` both high) shows WRITE (4'b0100) in the next cycle. That cycle carries the request's bank on `sd_ba`, its column on `sd_addr[COL_W-1:0]` and the auto-precharge flag on `sd_addr[10]`. Each written beat occupies one cycle with `sd_dq_oe`=1 and `sd_dqm`=0. The beats start in the WRITE cycle and run on consecutive cycles. Beat i carries the i-th word taken from `din`, and `din_take` is high in the cycle before the edge that takes a word. `req_len` and `req_keep` give counts minus one.
- R3: A request presented in the last beat cycle of a burst with no truncation and no auto precharge is accepted there. Its WRITE then follows in the very next cycle, to any bank.
- R4: With `req_cut`=1 (READ), a READ (4'b0101) shows in the cycle right after the last wanted beat. This includes the case where the wanted count equals the burst length, with no gap. The READ carries the same bank, `req_rd_col` as the column and `sd_addr[10]`=0. From the READ on, `sd_dq_oe` is 0 and no more words are taken. The auto-precharge flag is ignored for this choice, so the WRITE also carries `sd_addr[10]`=0.
- R5: With `req_cut`=2 (PRECHARGE) and no auto precharge, a PRECHARGE (4'b0010) with `sd_addr[10]`=0 to the same bank shows exactly `TWR_CYC` cycles after the cycle of the last wanted beat. This also holds when every beat is wanted.
- R6: From the cycle after the last wanted beat through the PRECHARGE cycle, `sd_dqm` is 1 and `sd_dq_oe` is 0. This covers both the edge before the PRECHARGE and the edge that coincides with it.
- R7: A PRECHARGE truncation requested together with auto precharge is not honoured. The full burst runs with `sd_addr[10]`=1 on the WRITE, and no PRECHARGE is issued.
- R8: After a PRECHARGE in cycle P, the earliest WRITE to that bank is in cycle P+`TRP_CYC`. Requests to other banks are not held back.
- R9: After an auto-precharge burst whose last beat is in cycle E, the earliest WRITE to that bank is in cycle E+`TWR_CYC`+`TRP_CYC`. This matches an explicit PRECHARGE at E+`TWR_CYC`.
- R10: NOP is driven in every cycle with no new command. `sd_dq_oe` is 0 and `sd_dqm` is 1 in every cycle that is not a wanted beat.
- R11: A `req_keep` larger than `req_len` is treated as equal to `req_len`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken on this edge if valid |
| req_bank | input | BA_W | Target bank |
| req_col | input | COL_W | Start column |
| req_len | input | $clog2(MAX_BL) | Burst length minus one |
| req_keep | input | $clog2(MAX_BL) | Wanted beats minus one |
| req_cut | input | 2 | 0 none, 1 end by READ, 2 end by PRECHARGE, 3 as 0 |
| req_autopre | input | 1 | Auto precharge on the WRITE |
| req_rd_col | input | COL_W | Column for a truncating READ |
| din | input | DQ_W | Write data stream |
| din_take | output | 1 | The word on `din` is taken on this edge |
| sd_cmd | output | 4 | {cs_n, ras_n, cas_n, we_n} |
| sd_ba | output | BA_W | Bank address |
| sd_addr | output | ADDR_W | Address bus (column, bit 10 precharge control) |
| sd_dq_out | output | DQ_W | Data bus output value |
| sd_dq_oe | output | 1 | Data bus drive enable |
| sd_dqm | output | 1 | Data mask (1 = masked) |

## Verification
Every request ends in one of three ways: it runs to the end, it is cut by a READ, or it is cut by a PRECHARGE. Each of these is tried with the wanted count at 1, in mid-burst, at the full length and past the full length. The cycle where the ending command lands then shows whether the block counts from the last wanted beat or from the burst end. Auto precharge is crossed with each ending, which separates a PRECHARGE truncation that is honoured from one that is refused. Requests to the same bank and to other banks are sent straight after PRECHARGE and auto-precharge bursts, and a back-to-back pair crosses banks, to show per-bank spacing apart from global stalling.

// File: rtl/sdram_wtrunc_seq.sv
`timescale 1ns/1ps
module sdram_wtrunc_seq #(
  parameter int BA_W    = 2,
  parameter int COL_W   = 8,
  parameter int ADDR_W  = 12,
  parameter int DQ_W    = 16,
  parameter int MAX_BL  = 8,
  parameter int TWR_CYC = 2,
  parameter int TRP_CYC = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [BA_W-1:0]            req_bank,
  input  logic [COL_W-1:0]           req_col,
  input  logic [$clog2(MAX_BL)-1:0]  req_len,
  input  logic [$clog2(MAX_BL)-1:0]  req_keep,
  input  logic [1:0]                 req_cut,
  input  logic                       req_autopre,
  input  logic [COL_W-1:0]           req_rd_col,
  input  logic [DQ_W-1:0]            din,
  output logic                       din_take,
  output logic [3:0]                 sd_cmd,
  output logic [BA_W-1:0]            sd_ba,
  output logic [ADDR_W-1:0]          sd_addr,
  output logic [DQ_W-1:0]            sd_dq_out,
  output logic                       sd_dq_oe,
  output logic                       sd_dqm
);
  localparam int BL_W   = $clog2(MAX_BL);
  localparam int NB     = 1 << BA_W;
  localparam int CNT_W  = $clog2(MAX_BL + TWR_CYC) + 1;
  localparam int TM_W   = $clog2(TWR_CYC + TRP_CYC) + 1;
  localparam int AP_BIT = 10;

  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_WR  = 4'b0100;
  localparam logic [3:0] C_RD  = 4'b0101;
  localparam logic [3:0] C_PRE = 4'b0010;

  localparam logic [1:0] M_NONE = 2'd0;
  localparam logic [1:0] M_RD   = 2'd1;
  localparam logic [1:0] M_PRE  = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_LAST} st_t;

  st_t               st;
  logic [CNT_W-1:0]  cnt;
  logic [BA_W-1:0]   cur_bank;
  logic [BL_W-1:0]   cur_last;
  logic [BL_W-1:0]   cur_want;
  logic [1:0]        cur_mode;
  logic              cur_ap;
  logic [COL_W-1:0]  cur_rdcol;
  logic [TM_W-1:0]   tmr [NB];

  logic [1:0]        mode_in;
  logic              ap_in;
  logic [BL_W-1:0]   keep_in;
  logic              last_beat, more_beat, pre_due, accept;

  function automatic logic [ADDR_W-1:0] mk_addr(input logic [COL_W-1:0] c, input logic ap);
    logic [ADDR_W-1:0] a;
    a = '0;
    a[COL_W-1:0] = c;
    a[AP_BIT] = ap;
    return a;
  endfunction

  assign mode_in  = (req_cut == M_RD || (req_cut == M_PRE && !req_autopre)) ? req_cut : M_NONE;
  assign ap_in    = req_autopre && (req_cut != M_RD);
  assign keep_in  = (mode_in == M_NONE || req_keep > req_len) ? req_len : req_keep;

  assign more_beat = (st == S_RUN) && (cnt < CNT_W'(cur_want));
  assign last_beat = (st == S_RUN) && (cur_mode == M_NONE) && (cnt == CNT_W'(cur_last));
  assign pre_due   = (st == S_RUN) && !more_beat && (cur_mode == M_PRE) &&
                     (CNT_W'(cnt + 1'b1) == CNT_W'(cur_want) + CNT_W'(TWR_CYC));

  assign req_ready = ((st == S_IDLE) || (last_beat && !cur_ap)) && (tmr[req_bank] == '0);
  assign accept    = req_valid && req_ready;
  assign din_take  = accept || more_beat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      cur_bank  <= '0;
      cur_last  <= '0;
      cur_want  <= '0;
      cur_mode  <= M_NONE;
      cur_ap    <= 1'b0;
      cur_rdcol <= '0;
      sd_cmd    <= C_NOP;
      sd_ba     <= '0;
      sd_addr   <= '0;
      sd_dq_out <= '0;
      sd_dq_oe  <= 1'b0;
      sd_dqm    <= 1'b1;
    end else begin
      sd_cmd   <= C_NOP;
      sd_dq_oe <= 1'b0;
      sd_dqm   <= 1'b1;
      if (din_take) sd_dq_out <= din;
      case (st)
        S_RUN: begin
          if (more_beat) begin
            cnt      <= cnt + 1'b1;
            sd_dq_oe <= 1'b1;
            sd_dqm   <= 1'b0;
          end else begin
            case (cur_mode)
              M_RD: begin
                st      <= S_LAST;
                sd_cmd  <= C_RD;
                sd_ba   <= cur_bank;
                sd_addr <= mk_addr(cur_rdcol, 1'b0);
              end
              M_PRE: begin
                cnt <= cnt + 1'b1;
                if (pre_due) begin
                  st      <= S_LAST;
                  sd_cmd  <= C_PRE;
                  sd_ba   <= cur_bank;
                  sd_addr <= '0;
                end
              end
              default: st <= S_IDLE;
            endcase
          end
        end
        S_LAST:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
      if (accept) begin
        st        <= S_RUN;
        cnt       <= '0;
        cur_bank  <= req_bank;
        cur_last  <= req_len;
        cur_want  <= keep_in;
        cur_mode  <= mode_in;
        cur_ap    <= ap_in;
        cur_rdcol <= req_rd_col;
        sd_cmd    <= C_WR;
        sd_ba     <= req_bank;
        sd_addr   <= mk_addr(req_col, ap_in);
        sd_dq_oe  <= 1'b1;
        sd_dqm    <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) tmr[i] <= '0;
    end else begin
      for (int i = 0; i < NB; i++) begin
        if (pre_due && cur_bank == BA_W'(i))
          tmr[i] <= TM_W'(TRP_CYC - 1);
        else if (last_beat && cur_ap && cur_bank == BA_W'(i))
          tmr[i] <= TM_W'(TWR_CYC + TRP_CYC - 2);
        else if (tmr[i] != '0)
          tmr[i] <= tmr[i] - 1'b1;
      end
    end
  end
endmodule

// File: rtl/sdram_wtrunc_seq_chk.sv
`timescale 1ns/1ps
module sdram_wtrunc_seq_chk #(
  parameter int BA_W    = 2,
  parameter int TWR_CYC = 2,
  parameter int TRP_CYC = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            din_take,
  input logic [3:0]      sd_cmd,
  input logic [BA_W-1:0] sd_ba,
  input logic            sd_dq_oe,
  input logic            sd_dqm
);
  localparam int NB = 1 << BA_W;
  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_WR  = 4'b0100;
  localparam logic [3:0] C_RD  = 4'b0101;
  localparam logic [3:0] C_PRE = 4'b0010;

  logic [7:0] beat_gap;
  logic [7:0] pre_gap [NB];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_gap <= 8'hFF;
      for (int i = 0; i < NB; i++) pre_gap[i] <= 8'hFF;
    end else begin
      if (sd_dq_oe && !sd_dqm) beat_gap <= 8'd1;
      else if (beat_gap != 8'hFF) beat_gap <= beat_gap + 8'd1;
      for (int i = 0; i < NB; i++) begin
        if (sd_cmd == C_PRE && sd_ba == BA_W'(i)) pre_gap[i] <= 8'd1;
        else if (pre_gap[i] != 8'hFF) pre_gap[i] <= pre_gap[i] + 8'd1;
      end
    end
  end

  assert_pre_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_cmd == C_PRE) |-> (sd_dqm && $past(sd_dqm) && !sd_dq_oe));

  assert_twr_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_cmd == C_PRE) |-> (beat_gap >= 8'(TWR_CYC)));

  assert_trp_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_cmd == C_WR) |-> (pre_gap[sd_ba] >= 8'(TRP_CYC)));

  assert_read_stops_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_cmd == C_RD) |-> (!sd_dq_oe && !din_take));

  assert_beat_unmasked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sd_dq_oe |-> !sd_dqm);

  assert_accept_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (sd_cmd == C_WR));

  assert_cmd_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_cmd == C_NOP || sd_cmd == C_WR || sd_cmd == C_RD || sd_cmd == C_PRE));
endmodule

bind sdram_wtrunc_seq sdram_wtrunc_seq_chk #(
  .BA_W(BA_W), .TWR_CYC(TWR_CYC), .TRP_CYC(TRP_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .din_take(din_take), .sd_cmd(sd_cmd), .sd_ba(sd_ba),
  .sd_dq_oe(sd_dq_oe), .sd_dqm(sd_dqm)
);

// File: tb/sdram_wtrunc_seq_bench.sv
`timescale 1ns/1ps
module sdram_wtrunc_seq_bench;
  localparam int BA_W = 2, COL_W = 8, ADDR_W = 12, DQ_W = 16, MAX_BL = 8;
  localparam int TWR_CYC = 2, TRP_CYC = 4;
  localparam int BL_W = $clog2(MAX_BL);
  localparam logic [3:0] C_NOP = 4'b0111, C_WR = 4'b0100, C_RD = 4'b0101, C_PRE = 4'b0010;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, req_valid, req_ready, req_autopre, din_take, sd_dq_oe, sd_dqm;
  logic [BA_W-1:0] req_bank, sd_ba;
  logic [COL_W-1:0] req_col, req_rd_col;
  logic [BL_W-1:0] req_len, req_keep;
  logic [1:0] req_cut;
  logic [DQ_W-1:0] din, sd_dq_out;
  logic [3:0] sd_cmd;
  logic [ADDR_W-1:0] sd_addr;

  sdram_wtrunc_seq #(.BA_W(BA_W), .COL_W(COL_W), .ADDR_W(ADDR_W), .DQ_W(DQ_W),
    .MAX_BL(MAX_BL), .TWR_CYC(TWR_CYC), .TRP_CYC(TRP_CYC)) u_sdram_wtrunc_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_col(req_col), .req_len(req_len), .req_keep(req_keep),
    .req_cut(req_cut), .req_autopre(req_autopre), .req_rd_col(req_rd_col),
    .din(din), .din_take(din_take), .sd_cmd(sd_cmd), .sd_ba(sd_ba), .sd_addr(sd_addr),
    .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe), .sd_dqm(sd_dqm));

  int checks = 0, fails = 0, cyc = 0, taken = 0, exp_base = 0;
  int free_at [4];
  bit ap_kind [4];

  function automatic logic [DQ_W-1:0] dword(input int x);
    return DQ_W'((x * 40503) ^ 23130);
  endfunction

  assign din = dword(taken);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (din_take) taken <= taken + 1;
  end

  task automatic chk(input string tag, input bit ok, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input int b, input int col, input int len, input int keep,
                       input int cut, input int ap, input int rdc, output int wc);
    int n, k, ew;
    @(negedge clk);
    req_bank = BA_W'(b); req_col = COL_W'(col); req_len = BL_W'(len);
    req_keep = BL_W'(keep); req_cut = 2'(cut); req_autopre = ap[0];
    req_rd_col = COL_W'(rdc); req_valid = 1'b1;
    n = cyc; k = 0;
    #1;
    while (!req_ready && k < 300) begin @(negedge clk); #1; k++; end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    wc = cyc;
    ew = (n + 1 > free_at[b]) ? n + 1 : free_at[b];
    chk(ap_kind[b] ? "R9 earliest write after auto precharge" : "R8 earliest write after precharge",
        wc == ew, 64'(wc), 64'(ew));
  endtask

  // Checks every cycle of one request starting at the negedge of its WRITE cycle.
  task automatic trace(input int b, input int col, input int L, input int W, input int md,
                       input int ap, input int rdc, input int wc, input bit stop, input string tg);
    int last_c, base;
    base = exp_base;
    last_c = (md == 0) ? L : (md == 1) ? W + 1 : W + TWR_CYC;
    if (stop) last_c = L - 1;
    for (int c = 0; c <= last_c; c++) begin
      logic [3:0] ec; logic edqm, eoe, cmp_ba; logic [ADDR_W-1:0] ea, amask;
      logic [63:0] act, exp; string tag;
      if (c > 0) @(negedge clk);
      ec = C_NOP; edqm = 1'b1; eoe = 1'b0; cmp_ba = 1'b0; ea = '0; amask = '0;
      tag = "R10 idle";
      if (c < W) begin
        edqm = 1'b0; eoe = 1'b1; tag = "R2 beat";
        if (c == 0) begin
          ec = C_WR; cmp_ba = 1'b1; amask = '1;
          ea = ADDR_W'(col) | (ap != 0 ? ADDR_W'(1024) : '0);
          tag = "R2 write cmd";
        end
      end else if (md == 1 && c == W) begin
        ec = C_RD; cmp_ba = 1'b1; amask = '1; ea = ADDR_W'(rdc); tag = "R4 read";
      end else if (md == 2 && c < W - 1 + TWR_CYC) begin
        tag = "R6 mask before precharge";
      end else if (md == 2 && c == W - 1 + TWR_CYC) begin
        ec = C_PRE; cmp_ba = 1'b1; amask = ADDR_W'(1024); tag = "R5 R6 precharge";
      end
      act = {sd_cmd, sd_dqm, sd_dq_oe, cmp_ba ? sd_ba : 2'b0, sd_addr & amask,
             eoe ? sd_dq_out : 16'h0, 24'h0};
      exp = {ec, edqm, eoe, cmp_ba ? 2'(b) : 2'b0, ea & amask,
             eoe ? dword(base + c) : 16'h0, 24'h0};
      chk({tg, tag}, act == exp, act, exp);
    end
    exp_base = base + W;
    if (!stop) chk({tg, "R4 R2 words taken"}, taken == exp_base, 64'(taken), 64'(exp_base));
    if (md == 2) begin
      free_at[b] = wc + W - 1 + TWR_CYC + TRP_CYC; ap_kind[b] = 1'b0;
    end else if (md == 0 && ap != 0) begin
      free_at[b] = wc + L - 1 + TWR_CYC + TRP_CYC; ap_kind[b] = 1'b1;
    end
  endtask

  task automatic do_req(input int b, input int col, input int len, input int keep,
                        input int cut, input int ap, input int rdc, input string tg);
    int wc, md, ape, L, W;
    md  = ((cut == 2 && ap != 0) || cut == 3) ? 0 : cut;
    ape = (ap != 0 && cut != 1) ? 1 : 0;
    L = len + 1;
    W = (md == 0) ? L : ((keep > len) ? len : keep) + 1;
    issue(b, col, len, keep, cut, ap, rdc, wc);
    trace(b, col, L, W, md, ape, rdc, wc, 1'b0, tg);
  endtask

  task automatic do_pair(input int b1, input int c1, input int l1,
                         input int b2, input int c2, input int l2);
    int wc;
    issue(b1, c1, l1, 0, 0, 0, 0, wc);
    trace(b1, c1, l1 + 1, l1 + 1, 0, 0, 0, wc, 1'b1, "R3 first ");
    req_bank = BA_W'(b2); req_col = COL_W'(c2); req_len = BL_W'(l2);
    req_keep = '0; req_cut = 2'd0; req_autopre = 1'b0; req_valid = 1'b1;
    #1;
    chk("R3 ready in last beat", req_ready == 1'b1, 64'(req_ready), 64'(1));
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R3 no gap between writes", cyc == wc + l1 + 1, 64'(cyc), 64'(wc + l1 + 1));
    trace(b2, c2, l2 + 1, l2 + 1, 0, 0, 0, cyc, 1'b0, "R3 second ");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog expired act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4; i++) begin free_at[i] = 0; ap_kind[i] = 1'b0; end
    rst_n = 1'b0; req_valid = 1'b0; req_bank = '0; req_col = '0; req_len = '0;
    req_keep = '0; req_cut = '0; req_autopre = 1'b0; req_rd_col = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset outputs", {sd_cmd, sd_dqm, sd_dq_oe, req_ready} == {C_NOP, 3'b101},
        64'({sd_cmd, sd_dqm, sd_dq_oe, req_ready}), 64'({C_NOP, 3'b101}));

    do_req(0, 8'h12, 3, 0, 0, 0, 0, "R2 plain ");
    do_pair(0, 8'h20, 2, 2, 8'h40, 3);
    do_pair(1, 8'h05, 0, 1, 8'h06, 0);
    do_req(0, 8'h30, 4, 4, 1, 0, 8'h77, "R4 full-length read ");
    do_req(3, 8'h31, 7, 0, 1, 1, 8'h01, "R4 read after one ");
    do_req(1, 8'h44, 7, 1, 2, 0, 0, "R5 early precharge ");
    do_req(2, 8'h45, 1, 0, 0, 0, 0, "R8 other bank ");
    do_req(1, 8'h46, 0, 0, 0, 0, 0, "R8 same bank ");
    do_req(3, 8'h50, 3, 3, 2, 0, 0, "R5 full burst precharge ");
    do_req(3, 8'h51, 3, 0, 0, 1, 0, "R9 auto precharge ");
    do_req(3, 8'h52, 2, 1, 2, 1, 0, "R7 refused truncation ");
    do_req(2, 8'h53, 2, 6, 1, 0, 8'h99, "R11 keep past length ");
    do_req(2, 8'h54, 1, 7, 2, 0, 0, "R11 keep past length ");
    do_req(0, 8'h55, 0, 0, 2, 0, 0, "R5 one beat ");
    do_req(0, 8'h56, 5, 2, 3, 0, 0, "R10 code three ");

    for (int i = 0; i < 90; i++)
      do_req($urandom % 4, $urandom % 256, $urandom % 8, $urandom % 8,
             $urandom % 4, $urandom % 2, $urandom % 256, "random ");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule